// File: doc/BRIEF.md
# Bank write sequencer

This block schedules write transactions against the banks of one DRAM device group and turns each one into a timed stream of abstract events on three channels. A row channel carries activates and precharges. A column channel carries write commands. A data channel marks the cycle in which each write's data (and, when requested, its byte mask) belongs. A request names a device, a bank, a row and up to `MAXC` column addresses. The block opens the row, issues the column writes in list order, closes the bank with a precharge, and then keeps the bank reserved until a new activate on it would be legal.

Each bank has its own controller and its own timing counters, so requests for different banks are accepted while other banks are still in flight, and their events interleave on the shared channels. When several banks are eligible for the same channel in one cycle, the bank whose request was accepted first wins. All gaps are counted in clock cycles between the cycles in which events appear on the ports. The data channel follows the column channel by a fixed delay, so the data timing is independent of command arbitration.

Top module: `bank_wr_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, all event valids are low, `bank_busy` is all zero and `req_ready` is high.
- R2: An activate appears with `row_is_pre`=0 and carries the request's device, bank and row. A precharge appears with `row_is_pre`=1, the same device and bank, and `row_addr` equal to zero.
- R3: The first write of a transaction appears no earlier than `T_RCD` cycles after its activate, and exactly `T_RCD` cycles after it when no other bank competes.
- R4: Writes of one transaction use the request's device and bank, carry the columns in list order (index 0 first, `req_cols[k*COL_W +: COL_W]` is entry k), number `req_nlast`+1, and are spaced at least `T_CC` cycles apart.
- R5: Exactly `T_CWD` cycles after each write, `dat_valid` is high with that write's bank and column; `msk_valid` is high in that same cycle only when the request had `req_mask`=1, and never without `dat_valid`.
- R6: A precharge appears no earlier than `T_RAS` cycles after the activate and no earlier than `T_RTP` cycles after the transaction's last write.
- R7: A bank stays busy after its precharge until both `T_RP` cycles after the precharge and `T_RC` cycles after the activate have elapsed; in that cycle `bank_done` pulses for one cycle and `bank_busy` drops.
- R8: `req_ready` is low whenever the addressed bank is busy; such a request is held and not taken until the bank is idle.
- R9: Requests to other banks are accepted while a bank is busy and their events interleave on the channels.
- R10: Each channel carries at most one event per cycle; among banks eligible in the same cycle, the one whose request was accepted earliest is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Addressed bank idle, request taken this cycle if valid |
| req_dev | input | DEV_W | Device address |
| req_bank | input | BANK_W | Bank address |
| req_row | input | ROW_W | Row address |
| req_cols | input | MAXC*COL_W | Column list, entry k at bits k*COL_W |
| req_nlast | input | NC_W | Index of the last column entry (count minus one) |
| req_mask | input | 1 | Emit a mask slot with each data slot |
| row_valid | output | 1 | Row channel event |
| row_is_pre | output | 1 | 0 activate, 1 precharge |
| row_dev | output | DEV_W | Device of row event |
| row_bank | output | BANK_W | Bank of row event |
| row_addr | output | ROW_W | Row of an activate, zero for precharge |
| col_valid | output | 1 | Column write event |
| col_dev | output | DEV_W | Device of write |
| col_bank | output | BANK_W | Bank of write |
| col_addr | output | COL_W | Column of write |
| dat_valid | output | 1 | Write-data slot |
| dat_bank | output | BANK_W | Bank of data slot |
| dat_col | output | COL_W | Column of data slot |
| msk_valid | output | 1 | Mask slot alongside the data slot |
| bank_busy | output | NB | Per-bank transaction in progress |
| bank_done | output | NB | Per-bank one-cycle completion pulse |

## Verification
The assertions watch, on every cycle, that a single grant at most goes out per channel, that a write grant never precedes the row-to-column delay, that a precharge grant respects both the activate window and the write-to-precharge window, that a recovering bank cannot leave recovery early, that a request is only taken by an idle bank, and that a mask slot never appears without a data slot. Arbitration order among competing banks, the column list order, the exact data-slot delay and the precise completion cycle are shown only by the bench's cycle-by-cycle reference model under directed and randomised request streams, together with directed measurements of the gaps in single-bank transactions where the activate window or the write-to-precharge window is the binding one.

// File: rtl/bwseq_pkg.sv
package bwseq_pkg;
  typedef enum logic [2:0] {
    BK_IDLE  = 3'd0,
    BK_ACTW  = 3'd1,
    BK_COLS  = 3'd2,
    BK_PREW  = 3'd3,
    BK_RECOV = 3'd4
  } bk_state_e;
endpackage

// File: rtl/bwseq_arb.sv
module bwseq_arb #(
  parameter int N     = 4,
  parameter int AGE_W = 8,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]            req_i,
  input  logic [N-1:0][AGE_W-1:0] age_i,
  output logic [N-1:0]            gnt_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic                    any_o
);
  logic [AGE_W-1:0] best;

  // oldest requester wins; equal ages fall to the lower index
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!any_o || age_i[i] > best)) begin
        any_o = 1'b1;
        best  = age_i[i];
        idx_o = IDX_W'(i);
      end
    end
    if (any_o) gnt_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/bwseq_delay.sv
module bwseq_delay #(
  parameter int DEPTH = 6,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  logic [DEPTH-1:0]        v_q;
  logic [DEPTH-1:0][W-1:0] d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      d_q <= '0;
    end else begin
      v_q[0] <= in_v;
      d_q[0] <= in_d;
      for (int i = 1; i < DEPTH; i++) begin
        v_q[i] <= v_q[i-1];
        d_q[i] <= d_q[i-1];
      end
    end
  end

  assign out_v = v_q[DEPTH-1];
  assign out_d = d_q[DEPTH-1];
endmodule

// File: rtl/bwseq_bank.sv
module bwseq_bank
  import bwseq_pkg::*;
#(
  parameter int DEV_W = 5,
  parameter int ROW_W = 9,
  parameter int COL_W = 7,
  parameter int MAXC  = 4,
  parameter int NC_W  = 2,
  parameter int CNT_W = 7,
  parameter int AGE_W = 8,
  parameter int T_RCD = 7,
  parameter int T_CC  = 4,
  parameter int T_RAS = 20,
  parameter int T_RTP = 4,
  parameter int T_RP  = 8,
  parameter int T_RC  = 28
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  accept_i,
  input  logic [DEV_W-1:0]      dev_i,
  input  logic [ROW_W-1:0]      row_i,
  input  logic [MAXC*COL_W-1:0] cols_i,
  input  logic [NC_W-1:0]       nlast_i,
  input  logic                  msk_i,
  input  logic                  row_gnt_i,
  input  logic                  col_gnt_i,
  output logic                  row_req_o,
  output logic                  row_pre_o,
  output logic                  col_req_o,
  output logic [DEV_W-1:0]      dev_o,
  output logic [ROW_W-1:0]      row_o,
  output logic [COL_W-1:0]      col_o,
  output logic                  msk_o,
  output logic [AGE_W-1:0]      age_o,
  output logic                  busy_o,
  output logic                  fin_o
);
  localparam logic [CNT_W-1:0] C_RCD = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] C_CC  = CNT_W'(T_CC);
  localparam logic [CNT_W-1:0] C_RAS = CNT_W'(T_RAS);
  localparam logic [CNT_W-1:0] C_RTP = CNT_W'(T_RTP);
  localparam logic [CNT_W-1:0] C_RP  = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] C_RC  = CNT_W'(T_RC);

  bk_state_e             st;
  logic [DEV_W-1:0]      dev_q;
  logic [ROW_W-1:0]      row_q;
  logic [MAXC*COL_W-1:0] cols_q;
  logic [NC_W-1:0]       nlast_q, cidx_q;
  logic                  msk_q;
  logic [CNT_W-1:0]      since_act, since_col, since_pre;
  logic [AGE_W-1:0]      age_q;
  logic                  win_ok, act_gnt, pre_gnt;

  // cycles since the last activate / write / precharge, saturating
  assign win_ok  = (since_pre >= C_RP) && (since_act >= C_RC);
  assign act_gnt = row_gnt_i && (st == BK_ACTW);
  assign pre_gnt = row_gnt_i && (st == BK_PREW);

  assign row_req_o = ((st == BK_ACTW) && win_ok) ||
                     ((st == BK_PREW) && (since_act >= C_RAS) && (since_col >= C_RTP));
  assign row_pre_o = (st == BK_PREW);
  assign col_req_o = (st == BK_COLS) && (since_act >= C_RCD) && (since_col >= C_CC);
  assign fin_o     = (st == BK_RECOV) && win_ok;
  assign busy_o    = (st != BK_IDLE);
  assign dev_o     = dev_q;
  assign row_o     = row_q;
  assign col_o     = cols_q[cidx_q*COL_W +: COL_W];
  assign msk_o     = msk_q;
  assign age_o     = age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_act <= '1;
      since_col <= '1;
      since_pre <= '1;
    end else begin
      since_act <= act_gnt   ? CNT_W'(1) : (&since_act ? since_act : since_act + 1'b1);
      since_col <= col_gnt_i ? CNT_W'(1) : (&since_col ? since_col : since_col + 1'b1);
      since_pre <= pre_gnt   ? CNT_W'(1) : (&since_pre ? since_pre : since_pre + 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= '0;
    end else if (accept_i) begin
      age_q <= '0;
    end else if (busy_o && !(&age_q)) begin
      age_q <= age_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= BK_IDLE;
      dev_q   <= '0;
      row_q   <= '0;
      cols_q  <= '0;
      nlast_q <= '0;
      cidx_q  <= '0;
      msk_q   <= 1'b0;
    end else begin
      unique case (st)
        BK_IDLE: if (accept_i) begin
          st      <= BK_ACTW;
          dev_q   <= dev_i;
          row_q   <= row_i;
          cols_q  <= cols_i;
          nlast_q <= nlast_i;
          msk_q   <= msk_i;
        end
        BK_ACTW: if (act_gnt) begin
          st     <= BK_COLS;
          cidx_q <= '0;
        end
        BK_COLS: if (col_gnt_i) begin
          if (cidx_q == nlast_q) st <= BK_PREW;
          else cidx_q <= cidx_q + 1'b1;
        end
        BK_PREW:  if (pre_gnt) st <= BK_RECOV;
        BK_RECOV: if (fin_o) st <= BK_IDLE;
        default:  st <= BK_IDLE;
      endcase
    end
  end

  // R8
  take_idle_chk: assert property (@(posedge clk) disable iff (rst)
    accept_i |-> (st == BK_IDLE));
  // R3
  rcd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    col_gnt_i |-> (since_act >= C_RCD));
  // R6
  pre_window_chk: assert property (@(posedge clk) disable iff (rst)
    pre_gnt |-> ((since_act >= C_RAS) && (since_col >= C_RTP)));
  // R7
  recov_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == BK_RECOV) && !win_ok) |=> (st == BK_RECOV));
endmodule

// File: rtl/bank_wr_seq.sv
module bank_wr_seq #(
  parameter int NB    = 4,
  parameter int DEV_W = 5,
  parameter int ROW_W = 9,
  parameter int COL_W = 7,
  parameter int MAXC  = 4,
  parameter int AGE_W = 8,
  parameter int T_RCD = 7,
  parameter int T_CWD = 6,
  parameter int T_CC  = 4,
  parameter int T_RAS = 20,
  parameter int T_RTP = 4,
  parameter int T_RP  = 8,
  parameter int T_RC  = 28,
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1,
  localparam int NC_W   = (MAXC > 1) ? $clog2(MAXC) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [DEV_W-1:0]      req_dev,
  input  logic [BANK_W-1:0]     req_bank,
  input  logic [ROW_W-1:0]      req_row,
  input  logic [MAXC*COL_W-1:0] req_cols,
  input  logic [NC_W-1:0]       req_nlast,
  input  logic                  req_mask,
  output logic                  row_valid,
  output logic                  row_is_pre,
  output logic [DEV_W-1:0]      row_dev,
  output logic [BANK_W-1:0]     row_bank,
  output logic [ROW_W-1:0]      row_addr,
  output logic                  col_valid,
  output logic [DEV_W-1:0]      col_dev,
  output logic [BANK_W-1:0]     col_bank,
  output logic [COL_W-1:0]      col_addr,
  output logic                  dat_valid,
  output logic [BANK_W-1:0]     dat_bank,
  output logic [COL_W-1:0]      dat_col,
  output logic                  msk_valid,
  output logic [NB-1:0]         bank_busy,
  output logic [NB-1:0]         bank_done
);
  localparam int T_SUM = T_RCD + T_CC + T_RAS + T_RTP + T_RP + T_RC + 2;
  localparam int CNT_W = $clog2(T_SUM);
  localparam int DW    = BANK_W + COL_W + 1;

  logic [NB-1:0]            row_req, row_pre, col_req, busy, fin, msk_v;
  logic [NB-1:0]            row_gnt, col_gnt;
  logic [NB-1:0][DEV_W-1:0] dev_v;
  logic [NB-1:0][ROW_W-1:0] row_v;
  logic [NB-1:0][COL_W-1:0] col_v;
  logic [NB-1:0][AGE_W-1:0] age_v;
  logic [BANK_W-1:0]        row_idx, col_idx;
  logic                     row_any, col_any, accept, col_msk_q;
  logic [DW-1:0]            dly_out;

  assign req_ready = !busy[req_bank];
  assign accept    = req_valid && req_ready;
  assign bank_busy = busy;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    bwseq_bank #(
      .DEV_W(DEV_W), .ROW_W(ROW_W), .COL_W(COL_W), .MAXC(MAXC), .NC_W(NC_W),
      .CNT_W(CNT_W), .AGE_W(AGE_W), .T_RCD(T_RCD), .T_CC(T_CC),
      .T_RAS(T_RAS), .T_RTP(T_RTP), .T_RP(T_RP), .T_RC(T_RC)
    ) u_bank (
      .clk(clk), .rst(rst),
      .accept_i(accept && (req_bank == BANK_W'(b))),
      .dev_i(req_dev), .row_i(req_row), .cols_i(req_cols),
      .nlast_i(req_nlast), .msk_i(req_mask),
      .row_gnt_i(row_gnt[b]), .col_gnt_i(col_gnt[b]),
      .row_req_o(row_req[b]), .row_pre_o(row_pre[b]), .col_req_o(col_req[b]),
      .dev_o(dev_v[b]), .row_o(row_v[b]), .col_o(col_v[b]), .msk_o(msk_v[b]),
      .age_o(age_v[b]), .busy_o(busy[b]), .fin_o(fin[b])
    );
  end

  bwseq_arb #(.N(NB), .AGE_W(AGE_W), .IDX_W(BANK_W)) u_row_arb (
    .req_i(row_req), .age_i(age_v), .gnt_o(row_gnt), .idx_o(row_idx), .any_o(row_any)
  );

  bwseq_arb #(.N(NB), .AGE_W(AGE_W), .IDX_W(BANK_W)) u_col_arb (
    .req_i(col_req), .age_i(age_v), .gnt_o(col_gnt), .idx_o(col_idx), .any_o(col_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_valid  <= 1'b0;
      row_is_pre <= 1'b0;
      row_dev    <= '0;
      row_bank   <= '0;
      row_addr   <= '0;
      col_valid  <= 1'b0;
      col_dev    <= '0;
      col_bank   <= '0;
      col_addr   <= '0;
      col_msk_q  <= 1'b0;
      bank_done  <= '0;
    end else begin
      row_valid  <= row_any;
      row_is_pre <= row_pre[row_idx];
      row_dev    <= dev_v[row_idx];
      row_bank   <= row_idx;
      row_addr   <= row_pre[row_idx] ? '0 : row_v[row_idx];
      col_valid  <= col_any;
      col_dev    <= dev_v[col_idx];
      col_bank   <= col_idx;
      col_addr   <= col_v[col_idx];
      col_msk_q  <= msk_v[col_idx];
      bank_done  <= fin;
    end
  end

  // data and mask slots trail the registered write by T_CWD cycles
  bwseq_delay #(.DEPTH(T_CWD), .W(DW)) u_dly (
    .clk(clk), .rst(rst),
    .in_v(col_valid), .in_d({col_bank, col_addr, col_msk_q}),
    .out_v(dat_valid), .out_d(dly_out)
  );

  assign dat_bank  = dly_out[DW-1 -: BANK_W];
  assign dat_col   = dly_out[COL_W:1];
  assign msk_valid = dat_valid && dly_out[0];

  // R10
  row_single_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(row_gnt));
  // R10
  col_single_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(col_gnt));
  // R5
  mask_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    msk_valid |-> dat_valid);
  // R7
  done_drops_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (|(bank_done & bank_busy)) == 1'b0);
endmodule

// File: tb/bank_wr_seq_tb_top.sv
`timescale 1ns/1ps
module bank_wr_seq_tb_top;
  localparam int NB = 4, DEV_W = 5, ROW_W = 9, COL_W = 7, MAXC = 4, AGE_W = 8;
  localparam int T_RCD = 7, T_CWD = 6, T_CC = 4, T_RAS = 20, T_RTP = 4, T_RP = 8, T_RC = 28;
  localparam int BANK_W = 2, NC_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic req_valid = 1'b0, req_mask = 1'b0;
  logic [DEV_W-1:0] req_dev = '0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [MAXC*COL_W-1:0] req_cols = '0;
  logic [NC_W-1:0] req_nlast = '0;
  logic req_ready, row_valid, row_is_pre, col_valid, dat_valid, msk_valid;
  logic [DEV_W-1:0] row_dev, col_dev;
  logic [BANK_W-1:0] row_bank, col_bank, dat_bank;
  logic [ROW_W-1:0] row_addr;
  logic [COL_W-1:0] col_addr, dat_col;
  logic [NB-1:0] bank_busy, bank_done;

  bank_wr_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_dev(req_dev), .req_bank(req_bank), .req_row(req_row), .req_cols(req_cols),
    .req_nlast(req_nlast), .req_mask(req_mask),
    .row_valid(row_valid), .row_is_pre(row_is_pre), .row_dev(row_dev),
    .row_bank(row_bank), .row_addr(row_addr),
    .col_valid(col_valid), .col_dev(col_dev), .col_bank(col_bank), .col_addr(col_addr),
    .dat_valid(dat_valid), .dat_bank(dat_bank), .dat_col(dat_col), .msk_valid(msk_valid),
    .bank_busy(bank_busy), .bank_done(bank_done)
  );

  int checks = 0, fails = 0;
  int cyc = 0;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mst[NB], g_act[NB], g_col[NB], g_pre[NB], acc_t[NB];
  int m_dev[NB], m_row[NB], m_nlast[NB], m_cidx[NB], m_msk[NB];
  int m_cols[NB][MAXC];
  int e_row_v, e_row_pre, e_row_dev, e_row_bank, e_row_addr;
  int e_col_v, e_col_dev, e_col_bank, e_col_addr;
  int e_busy, e_done;
  int ds_v[64], ds_bank[64], ds_col[64], ds_msk[64];

  always @(posedge clk) begin
    if (rst) begin
      cyc = 0;
      for (int b = 0; b < NB; b++) begin
        mst[b] = 0; g_act[b] = -1000; g_col[b] = -1000; g_pre[b] = -1000; acc_t[b] = 0;
      end
      for (int s = 0; s < 64; s++) ds_v[s] = 0;
      e_row_v = 0; e_col_v = 0; e_busy = 0; e_done = 0;
    end else begin
      int n, rb, rw, cw;
      bit acc, el;
      bit fin[NB];
      n = cyc;
      rb = int'(req_bank);
      acc = req_valid && (mst[rb] == 0);
      rw = -1; cw = -1;
      for (int b = 0; b < NB; b++) begin
        el = (mst[b] == 1 && n - g_pre[b] >= T_RP && n - g_act[b] >= T_RC) ||
             (mst[b] == 3 && n - g_act[b] >= T_RAS && n - g_col[b] >= T_RTP);
        if (el && (rw < 0 || acc_t[b] < acc_t[rw])) rw = b;
        el = (mst[b] == 2 && n - g_act[b] >= T_RCD && n - g_col[b] >= T_CC);
        if (el && (cw < 0 || acc_t[b] < acc_t[cw])) cw = b;
        fin[b] = (mst[b] == 4 && n - g_pre[b] >= T_RP && n - g_act[b] >= T_RC);
      end
      e_row_v = (rw >= 0);
      if (rw >= 0) begin
        e_row_pre = (mst[rw] == 3);
        e_row_dev = m_dev[rw];
        e_row_bank = rw;
        e_row_addr = e_row_pre ? 0 : m_row[rw];
        if (mst[rw] == 1) begin g_act[rw] = n; mst[rw] = 2; m_cidx[rw] = 0; end
        else begin g_pre[rw] = n; mst[rw] = 4; end
      end
      e_col_v = (cw >= 0);
      if (cw >= 0) begin
        int s;
        e_col_dev = m_dev[cw];
        e_col_bank = cw;
        e_col_addr = m_cols[cw][m_cidx[cw]];
        s = (n + 1 + T_CWD) % 64;
        ds_v[s] = 1; ds_bank[s] = cw; ds_col[s] = e_col_addr; ds_msk[s] = m_msk[cw];
        g_col[cw] = n;
        if (m_cidx[cw] == m_nlast[cw]) mst[cw] = 3;
        else m_cidx[cw]++;
      end
      e_done = 0;
      for (int b = 0; b < NB; b++) if (fin[b]) begin e_done |= (1 << b); mst[b] = 0; end
      if (acc) begin
        mst[rb] = 1; acc_t[rb] = n;
        m_dev[rb] = int'(req_dev); m_row[rb] = int'(req_row);
        m_nlast[rb] = int'(req_nlast); m_msk[rb] = int'(req_mask);
        for (int k = 0; k < MAXC; k++) m_cols[rb][k] = int'(req_cols[k*COL_W +: COL_W]);
      end
      e_busy = 0;
      for (int b = 0; b < NB; b++) if (mst[b] != 0) e_busy |= (1 << b);
      cyc = n + 1;
    end
  end

  // ---------------- per-cycle comparison, away from the edge ----------------
  always @(negedge clk) begin
    if (!rst) begin
      int s;
      chk("R10 row channel event", int'(row_valid), e_row_v);
      if (row_valid && e_row_v) begin
        chk("R2 row kind", int'(row_is_pre), e_row_pre);
        chk("R2 row device", int'(row_dev), e_row_dev);
        chk("R10 row bank order", int'(row_bank), e_row_bank);
        chk("R2 row address", int'(row_addr), e_row_addr);
      end
      chk("R10 column channel event", int'(col_valid), e_col_v);
      if (col_valid && e_col_v) begin
        chk("R4 write device", int'(col_dev), e_col_dev);
        chk("R10 write bank order", int'(col_bank), e_col_bank);
        chk("R4 write column", int'(col_addr), e_col_addr);
      end
      s = cyc % 64;
      chk("R5 data slot", int'(dat_valid), ds_v[s]);
      if (dat_valid && ds_v[s]) begin
        chk("R5 data bank", int'(dat_bank), ds_bank[s]);
        chk("R5 data column", int'(dat_col), ds_col[s]);
      end
      chk("R5 mask slot", int'(msk_valid), (ds_v[s] != 0 && ds_msk[s] != 0) ? 1 : 0);
      ds_v[s] = 0;
      chk("R7 busy", int'(bank_busy), e_busy);
      chk("R7 done", int'(bank_done), e_done);
      chk("R8 ready", int'(req_ready), (mst[int'(req_bank)] == 0) ? 1 : 0);
    end
  end

  // ---------------- port monitor for directed gap checks ----------------
  int mon_act[NB], mon_fcol[NB], mon_lcol[NB], mon_pre[NB], mon_done[NB], mon_dat[NB];
  int mon_ncol[NB], mon_gap[NB];
  bit overlap_seen = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (row_valid && !row_is_pre) begin
        mon_act[row_bank] = cyc; mon_ncol[row_bank] = 0; mon_gap[row_bank] = 1000;
      end
      if (row_valid && row_is_pre) mon_pre[row_bank] = cyc;
      if (col_valid) begin
        if (mon_ncol[col_bank] == 0) mon_fcol[col_bank] = cyc;
        else if (cyc - mon_lcol[col_bank] < mon_gap[col_bank]) mon_gap[col_bank] = cyc - mon_lcol[col_bank];
        mon_lcol[col_bank] = cyc;
        mon_ncol[col_bank]++;
      end
      if (dat_valid) mon_dat[dat_bank] = cyc;
      for (int b = 0; b < NB; b++) if (bank_done[b]) mon_done[b] = cyc;
      if ($countones(bank_busy) >= 2) overlap_seen = 1;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input int b, input int dv, input int rw, input int nl,
                      input int c0, input int c1, input int c2, input int c3, input bit mk);
    bit ok;
    req_bank  = BANK_W'(b);
    req_dev   = DEV_W'(dv);
    req_row   = ROW_W'(rw);
    req_nlast = NC_W'(nl);
    req_cols  = {COL_W'(c3), COL_W'(c2), COL_W'(c1), COL_W'(c0)};
    req_mask  = mk;
    req_valid = 1'b1;
    forever begin
      #1 ok = req_ready;
      @(posedge clk);
      @(negedge clk);
      #0.5;
      if (ok) break;
    end
    req_valid = 1'b0;
  endtask

  task automatic idle_cycles(input int k);
    repeat (k) @(negedge clk);
    #0.5;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: outputs under reset
    chk("R1 row valid in reset", int'(row_valid), 0);
    chk("R1 busy in reset", int'(bank_busy), 0);
    chk("R1 ready in reset", int'(req_ready), 1);
    #0.5 rst = 1'b0;
    idle_cycles(1);
    chk("R1 write valid after reset", int'(col_valid), 0);
    chk("R1 data valid after reset", int'(dat_valid), 0);

    // single write: activate window binds the precharge
    send(0, 3, 9'h055, 0, 7'h11, 0, 0, 0, 1'b1);
    idle_cycles(40);
    chk("R3 activate to first write", mon_fcol[0] - mon_act[0], T_RCD);
    chk("R5 write to data slot", mon_dat[0] - mon_lcol[0], T_CWD);
    chk("R6 precharge after activate", mon_pre[0] - mon_act[0], T_RAS);
    chk("R7 activate to done", mon_done[0] - mon_act[0], T_RC);

    // four writes: write-to-precharge binds
    send(0, 4, 9'h1a2, 3, 7'h01, 7'h22, 7'h43, 7'h64, 1'b0);
    idle_cycles(45);
    chk("R4 write count", mon_ncol[0], 4);
    chk("R4 write spacing", mon_gap[0], T_CC);
    chk("R6 last write to precharge", mon_pre[0] - mon_lcol[0], T_RTP);
    chk("R7 recovery after precharge", mon_done[0] - mon_act[0], T_RCD + 3*T_CC + T_RTP + T_RP);

    // busy bank holds a second request
    send(1, 7, 9'h003, 1, 7'h05, 7'h06, 0, 0, 1'b1);
    req_bank = 2'd1; req_valid = 1'b0;
    #1 chk("R8 ready low for busy bank", int'(req_ready), 0);
    #0.5;
    begin
      int first_done;
      send(1, 7, 9'h004, 0, 7'h07, 0, 0, 0, 1'b0);
      first_done = mon_done[1];
      idle_cycles(40);
      chk("R8 second activate after completion", (mon_act[1] > first_done) ? 1 : 0, 1);
    end

    // two banks competing for the channels
    send(2, 1, 9'h010, 3, 7'h10, 7'h11, 7'h12, 7'h13, 1'b1);
    idle_cycles(3);
    send(3, 2, 9'h020, 3, 7'h20, 7'h21, 7'h22, 7'h23, 1'b0);
    idle_cycles(50);
    chk("R9 two banks in flight together", int'(overlap_seen), 1);
    chk("R10 older bank first write unmoved", mon_fcol[2] - mon_act[2], T_RCD);

    // randomised stream
    for (int i = 0; i < 80; i++) begin
      send($urandom_range(0, NB-1), $urandom_range(0, 31), $urandom_range(0, 511),
           $urandom_range(0, MAXC-1), $urandom_range(0, 127), $urandom_range(0, 127),
           $urandom_range(0, 127), $urandom_range(0, 127), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) idle_cycles($urandom_range(1, 12));
    end
    idle_cycles(60);
    chk("R7 all banks idle at end", int'(bank_busy), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule